// File: doc/BRIEF.md
# Supply power-up sequencer

This block steps a supply subsystem from a cold start to regulated operation. It takes digitized status lines from analog circuitry: a raw supply-above-minimum flag, a reference-settled flag, a regulator-type select and the raw outputs of the low-voltage detectors. It drives a held system reset, a detector enable, masked detector outputs, one enable per regulator type and a soft-start ramp code that rises in steps.

Each status line passes through a debouncer before the sequencer acts on it. The sequencer holds reset while the supply is low. It waits for the reference to settle, then enables the detectors and starts the selected regulator. The regulator target is ramped one code at a time, and reset is released once the ramp is complete. Until that point every detector output is forced to the low-voltage level, so logic downstream never sees a false all-clear during the sequence. A supply loss at any time sends the sequencer straight back to the reset state.

Top module: `pwrseq_ctrl`

## Requirements
- R1: From reset, and while the debounced supply indication is low, `sys_rst_o` is 1, and `lvd_en_o`, `ldo_en_o`, `smps_en_o`, `ramp_code_o` and `ramp_done_o` are all 0.
- R2: A status input (`supply_ok_i`, `ref_ok_i`, each `lvd_raw_i` bit) is acted on only after it has held a new value on DEB_CYC consecutive clock edges. A shorter pulse has no effect at the outputs.
- R3: `lvd_en_o` rises only once the debounced supply is high and, after that, the debounced reference is high. It rises on the clock edge that follows the edge on which the debounced reference rises.
- R4: While `sys_rst_o` is 1, `lvd_o` is all ones (1 = low voltage detected). While `sys_rst_o` is 0, `lvd_o` equals the debounced `lvd_raw_i`.
- R5: `reg_sel_i` = 0 selects the linear low-dropout regulator (`ldo_en_o`) and 1 selects the switched-mode regulator (`smps_en_o`). Only the selected enable is driven, and only while `lvd_en_o` is 1. The two enables are never high together.
- R6: `reg_sel_i` is sampled on the edge where the sequencer leaves the reset state. Later changes to it have no effect until the next power-up.
- R7: On ramp start `ramp_code_o` is 0. It rises by exactly 1 every STEP_CYC cycles and stops at FINAL_CODE. `ramp_done_o` is 1 only when the code equals FINAL_CODE.
- R8: `sys_rst_o` falls one cycle after `ramp_done_o` rises. `lvd_o` becomes unmasked in that same cycle.
- R9: When the debounced supply falls in any state, the next clock edge returns the block to the R1 output state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Raw flag: regulator supply is above the minimum |
| ref_ok_i | input | 1 | Raw flag: current and voltage references are stable |
| reg_sel_i | input | 1 | Regulator type: 0 low-dropout, 1 switched-mode |
| lvd_raw_i | input | NUM_LVD | Raw detector outputs, 1 = low voltage |
| sys_rst_o | output | 1 | System reset, 1 = held |
| lvd_en_o | output | 1 | Detector enable |
| lvd_o | output | NUM_LVD | Masked detector outputs |
| ldo_en_o | output | 1 | Low-dropout regulator enable |
| smps_en_o | output | 1 | Switched-mode regulator enable |
| ramp_code_o | output | CODE_W | Soft-start target code |
| ramp_done_o | output | 1 | Ramp reached FINAL_CODE |

## Verification
A change on a status input shows in its filtered value after DEB_CYC edges. The state register reacts one edge later, and all outputs decode state combinationally. So a supply or reference change is visible at the outputs DEB_CYC+1 edges after it is driven, and a detector change in run state after DEB_CYC edges. The ramp code first steps STEP_CYC edges after ramp entry and reaches FINAL_CODE after FINAL_CODE*STEP_CYC edges, with reset released one edge later. The bench drives inputs on the falling edge, counts rising edges exactly, and samples both one edge before and on the edge each result is due, so an off-by-one in either direction is caught.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_WAIT_REF = 2'd1,
    ST_RAMP     = 2'd2,
    ST_RUN      = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_debounce.sv
module pwrseq_debounce #(
  parameter int unsigned DEB_CYC = 4,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      filt_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
  parameter int unsigned STEP_CYC   = 8,
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned FINAL_CODE = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int unsigned DW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [DW-1:0]     DLAST = DW'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] FINAL = CODE_W'(FINAL_CODE);

  logic [DW-1:0]     div_q;
  logic [CODE_W-1:0] code_q;
  logic              done;

  assign done = (code_q == FINAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      code_q <= '0;
    end else if (!run_i) begin
      div_q  <= '0;
      code_q <= '0;
    end else if (!done) begin
      if (div_q == DLAST) begin
        div_q  <= '0;
        code_q <= code_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign code_o = code_q;
  assign done_o = done;
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       ref_ok_i,
  input  logic       sel_i,
  input  logic       ramp_done_i,
  output pwr_state_e state_o,
  output logic       sel_o
);
  pwr_state_e state_q, state_d;
  logic       sel_q;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:      state_d = ST_WAIT_REF;
        ST_WAIT_REF: if (ref_ok_i) state_d = ST_RAMP;
        ST_RAMP:     if (ramp_done_i) state_d = ST_RUN;
        ST_RUN:      state_d = ST_RUN;
        default:     state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      // latch regulator choice when leaving reset only
      if (state_q == ST_OFF && supply_ok_i) sel_q <= sel_i;
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int unsigned NUM_LVD    = 3,
  parameter int unsigned DEB_CYC    = 4,
  parameter int unsigned STEP_CYC   = 8,
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned FINAL_CODE = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               supply_ok_i,
  input  logic               ref_ok_i,
  input  logic               reg_sel_i,
  input  logic [NUM_LVD-1:0] lvd_raw_i,
  output logic               sys_rst_o,
  output logic               lvd_en_o,
  output logic [NUM_LVD-1:0] lvd_o,
  output logic               ldo_en_o,
  output logic               smps_en_o,
  output logic [CODE_W-1:0]  ramp_code_o,
  output logic               ramp_done_o
);
  logic               supply_f, ref_f;
  logic [NUM_LVD-1:0] lvd_f;
  logic               sel_q, active, ramp_done;
  logic [CODE_W-1:0]  ramp_code;
  pwr_state_e         state;

  pwrseq_debounce #(.DEB_CYC(DEB_CYC), .RST_VAL(1'b0)) u_deb_sup (
    .clk_i, .rst_ni, .raw_i(supply_ok_i), .filt_o(supply_f)
  );

  pwrseq_debounce #(.DEB_CYC(DEB_CYC), .RST_VAL(1'b0)) u_deb_ref (
    .clk_i, .rst_ni, .raw_i(ref_ok_i), .filt_o(ref_f)
  );

  for (genvar i = 0; i < NUM_LVD; i++) begin : g_lvd
    pwrseq_debounce #(.DEB_CYC(DEB_CYC), .RST_VAL(1'b1)) u_deb_lvd (
      .clk_i, .rst_ni, .raw_i(lvd_raw_i[i]), .filt_o(lvd_f[i])
    );
  end

  pwrseq_fsm u_fsm (
    .clk_i, .rst_ni,
    .supply_ok_i(supply_f),
    .ref_ok_i   (ref_f),
    .sel_i      (reg_sel_i),
    .ramp_done_i(ramp_done),
    .state_o    (state),
    .sel_o      (sel_q)
  );

  assign active = (state == ST_RAMP) || (state == ST_RUN);

  pwrseq_ramp #(.STEP_CYC(STEP_CYC), .CODE_W(CODE_W), .FINAL_CODE(FINAL_CODE)) u_ramp (
    .clk_i, .rst_ni, .run_i(active), .code_o(ramp_code), .done_o(ramp_done)
  );

  assign sys_rst_o   = (state != ST_RUN);
  assign lvd_en_o    = active;
  assign ldo_en_o    = active & ~sel_q;
  assign smps_en_o   = active & sel_q;
  assign ramp_code_o = active ? ramp_code : '0;
  assign ramp_done_o = active & ramp_done;
  assign lvd_o       = (state == ST_RUN) ? lvd_f : '1;
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk #(
  parameter int unsigned NUM_LVD    = 3,
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned FINAL_CODE = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sys_rst_o,
  input logic               lvd_en_o,
  input logic [NUM_LVD-1:0] lvd_o,
  input logic               ldo_en_o,
  input logic               smps_en_o,
  input logic [CODE_W-1:0]  ramp_code_o,
  input logic               ramp_done_o
);
  assert_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (lvd_o == {NUM_LVD{1'b1}}));

  assert_reg_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvd_en_o |-> (!ldo_en_o && !smps_en_o));

  assert_reg_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ldo_en_o, smps_en_o}));

  assert_sel_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldo_en_o || smps_en_o) |=> (!(ldo_en_o || smps_en_o) || $stable({ldo_en_o, smps_en_o})));

  assert_ramp_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_en_o |=> (ramp_code_o == $past(ramp_code_o)
               || ramp_code_o == CODE_W'($past(ramp_code_o) + 1'b1)
               || ramp_code_o == '0));

  assert_ramp_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_done_o |-> (ramp_code_o == CODE_W'(FINAL_CODE)));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_o |-> (ramp_done_o && lvd_en_o));

  assert_release_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> $past(ramp_done_o));

  assert_off_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvd_en_o |-> (ramp_code_o == '0 && !ramp_done_o && sys_rst_o));
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(
  .NUM_LVD(NUM_LVD), .CODE_W(CODE_W), .FINAL_CODE(FINAL_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_o(sys_rst_o), .lvd_en_o(lvd_en_o),
  .lvd_o(lvd_o), .ldo_en_o(ldo_en_o), .smps_en_o(smps_en_o),
  .ramp_code_o(ramp_code_o), .ramp_done_o(ramp_done_o)
);

// File: tb/sim_pwrseq_ctrl.sv
`timescale 1ns/1ps
module sim_pwrseq_ctrl;
  localparam int NL  = 3;
  localparam int DEB = 4;
  localparam int STP = 8;
  localparam int CW  = 6;
  localparam int FIN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply = 1'b0, refok = 1'b0, sel = 1'b0;
  logic [NL-1:0] lvd_raw = '0;
  logic sys_rst, lvd_en, ldo_en, smps_en, rdone;
  logic [NL-1:0] lvd;
  logic [CW-1:0] code;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwrseq_ctrl #(.NUM_LVD(NL), .DEB_CYC(DEB), .STEP_CYC(STP), .CODE_W(CW), .FINAL_CODE(FIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply), .ref_ok_i(refok), .reg_sel_i(sel),
    .lvd_raw_i(lvd_raw), .sys_rst_o(sys_rst), .lvd_en_o(lvd_en), .lvd_o(lvd),
    .ldo_en_o(ldo_en), .smps_en_o(smps_en), .ramp_code_o(code), .ramp_done_o(rdone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_off(input string req);
    chk({req, " sys_rst"}, 32'(sys_rst), 32'd1);
    chk({req, " lvd_en"}, 32'(lvd_en), 32'd0);
    chk({req, " reg_en"}, 32'({ldo_en, smps_en}), 32'd0);
    chk({req, " code"}, 32'(code), 32'd0);
    chk({req, " done"}, 32'(rdone), 32'd0);
    chk({req, " lvd_mask"}, 32'(lvd), 32'((1 << NL) - 1));
  endtask

  task automatic power_down();
    @(negedge clk);
    supply = 1'b0;
    refok  = 1'b0;
    tick(DEB + 2);
    chk_off("R9 settle");
  endtask

  task automatic t_reset();
    chk_off("R1 in reset");
    rst_n = 1'b1;
    tick(DEB + 3);
    chk_off("R1 supply low");
  endtask

  task automatic t_power_up(input logic sel_start, input logic sel_after);
    @(negedge clk);
    sel    = sel_start;
    supply = 1'b1;
    tick(DEB);
    chk("R2 supply not yet acted", 32'(sys_rst), 32'd1);
    tick(1);
    chk("R3 no enable before ref", 32'(lvd_en), 32'd0);
    @(negedge clk);
    sel   = sel_after;
    refok = 1'b1;
    tick(DEB);
    chk("R2 ref not yet acted", 32'(lvd_en), 32'd0);
    tick(1);
    chk("R3 lvd_en after ref", 32'(lvd_en), 32'd1);
    chk("R5 ldo_en", 32'(ldo_en), 32'(!sel_start));
    chk("R6 smps_en uses latched sel", 32'(smps_en), 32'(sel_start));
    chk("R7 code starts 0", 32'(code), 32'd0);
    chk("R4 masked during ramp", 32'(lvd), 32'((1 << NL) - 1));
    tick(STP - 1);
    chk("R7 code before first step", 32'(code), 32'd0);
    tick(1);
    chk("R7 first step", 32'(code), 32'd1);
    tick((FIN - 1) * STP - 1);
    chk("R7 one before final", 32'(rdone), 32'd0);
    tick(1);
    chk("R7 final code", 32'(code), 32'(FIN));
    chk("R7 done", 32'(rdone), 32'd1);
    chk("R8 reset held at done", 32'(sys_rst), 32'd1);
    tick(1);
    chk("R8 reset released", 32'(sys_rst), 32'd0);
    chk("R8 unmasked", 32'(lvd), 32'(lvd_raw));
    chk("R7 code holds", 32'(code), 32'(FIN));
    chk("R6 sel still latched", 32'(smps_en), 32'(sel_start));
  endtask

  task automatic t_lvd_pass();
    @(negedge clk);
    lvd_raw = 3'b010;
    tick(DEB - 1);
    chk("R2 lvd not yet", 32'(lvd), 32'd0);
    tick(1);
    chk("R4 lvd passes", 32'(lvd), 32'b010);
    @(negedge clk);
    lvd_raw = 3'b000;
    tick(DEB - 2);
    @(negedge clk);
    lvd_raw = 3'b010;
    tick(DEB + 1);
    chk("R2 short clear ignored", 32'(lvd), 32'b010);
    @(negedge clk);
    lvd_raw = 3'b000;
    tick(DEB);
    chk("R4 lvd clears", 32'(lvd), 32'd0);
  endtask

  task automatic t_drop_run();
    @(negedge clk);
    supply = 1'b0;
    tick(DEB);
    chk("R9 still running before debounce", 32'(sys_rst), 32'd0);
    tick(1);
    chk_off("R9 drop in run");
    power_down();
  endtask

  task automatic t_drop_ramp();
    @(negedge clk);
    sel    = 1'b1;
    supply = 1'b1;
    tick(DEB + 1);
    @(negedge clk);
    refok = 1'b1;
    tick(DEB + 1 + 3 * STP);
    chk("R7 mid ramp code", 32'(code), 32'd3);
    chk("R5 smps mid ramp", 32'(smps_en), 32'd1);
    @(negedge clk);
    supply = 1'b0;
    tick(DEB + 1);
    chk_off("R9 drop in ramp");
    power_down();
  endtask

  task automatic t_glitch();
    @(negedge clk);
    refok = 1'b1;
    tick(DEB + 2);
    @(negedge clk);
    supply = 1'b1;
    tick(DEB - 1);
    @(negedge clk);
    supply = 1'b0;
    tick(DEB + 3);
    chk("R2 supply glitch ignored", 32'(lvd_en), 32'd0);
    chk("R1 reset held after glitch", 32'(sys_rst), 32'd1);
    @(negedge clk);
    sel    = 1'b0;
    supply = 1'b1;
    tick(DEB + 1);
    chk("R3 waits one state after supply", 32'(lvd_en), 32'd0);
    tick(1);
    chk("R3 enable with ref already stable", 32'(lvd_en), 32'd1);
    chk("R5 ldo selected", 32'(ldo_en), 32'd1);
    power_down();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    t_power_up(1'b0, 1'b0);
    t_lvd_pass();
    t_drop_run();
    t_power_up(1'b1, 1'b0);
    t_drop_run();
    t_drop_ramp();
    t_glitch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule